// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is the coherence controller of one private, direct-mapped, write-back cache in a small bus-based multiprocessor. It keeps its copies consistent with the other caches on the bus by pushing each stored word to every other holder. The other copies are never invalidated. A line that is present has one of four states: exclusive-clean, shared-clean, shared-owned or dirty-private. A line that is absent is simply not valid, and no state is kept for it.

On the processor side the block takes one read or write at a time and answers with a single-cycle `cpu_ready` pulse. On the bus side it requests the bus, waits for the grant, and then runs one transaction in the grant cycle:
- a block fetch (code 1);
- a one-word update broadcast (code 2);
- a block write-back (code 3).

The bus must show every fetch and every update to all the other controllers on their snoop inputs in that same cycle. The other controllers answer in that cycle on their share line and their supply line. The fabric ORs the share answers into `bus_shared_i`. When a supplier exists, its block replaces the memory data on `bus_blk_i`.

Top module: `wupd_cache_ctrl`

## Requirements
- R1: A read miss issues a block fetch (code 1). The line fills as shared-clean when `bus_shared_i` is high in the grant cycle, and as exclusive-clean otherwise. The read returns the fetched word.
- R2: A write miss issues a block fetch. If the fetch saw sharers, the controller then issues a one-word update (code 2) and ends as shared-owned. Otherwise it ends dirty-private, with no update.
- R3: A write hit to an exclusive-clean or dirty-private line completes with no bus transaction and leaves the line dirty-private.
- R4: A write hit to a shared-clean or shared-owned line issues one update. The line becomes shared-owned if `bus_shared_i` is high, and dirty-private otherwise.
- R5: A snooped update that hits a shared line writes the carried word into the local copy and leaves the line shared-clean.
- R6: A snooped fetch that hits asserts `snp_shared_o`. A dirty-private line supplies its block on `snp_blk_o` with `snp_flush_o` and becomes shared-owned. A shared-owned line supplies its block and stays shared-owned. An exclusive-clean line becomes shared-clean and does not supply.
- R7: An update carries exactly one word: `bus_word_o` holds the data and `bus_addr_o` holds its word address.
- R8: A miss that displaces a shared-owned or dirty-private line first writes the whole block back (code 3) and then fetches. A displaced clean line is dropped with no bus transaction.
- R9: At most one cache supplies data for any fetch, so at most one cache owns a given line at a time.
- R10: A read hit returns the cached word with no bus transaction. Each request is answered by a `cpu_ready` pulse that lasts exactly one cycle.
- R11: After reset no line is valid, `bus_req_o` and `cpu_ready` are low, and no snoop hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Grant; the transaction happens in this cycle |
| bus_cmd_o | output | 2 | 0 none, 1 fetch, 2 update, 3 write-back |
| bus_addr_o | output | AW | Block base for fetch/write-back, word address for update |
| bus_word_o | output | DW | Word carried by an update |
| bus_blk_o | output | WORDS*DW | Block carried by a write-back |
| bus_blk_i | input | WORDS*DW | Fill data for a fetch |
| bus_shared_i | input | 1 | ORed share line from the other caches |
| snp_valid_i | input | 1 | Another cache's fetch or update is on the bus |
| snp_cmd_i | input | 2 | Snooped command code |
| snp_addr_i | input | AW | Snooped address |
| snp_word_i | input | DW | Word carried by a snooped update |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_flush_o | output | 1 | This cache supplies the snooped block |
| snp_blk_o | output | WORDS*DW | Supplied block |

## Verification
The assertions assume a serial bus. A controller never sees a snoop in a cycle in which it holds the grant, and snoops carry only fetch or update codes. The assertions also take the share input to be the OR of the other caches' answers to the current transaction. The bench's behavioural fabric grants one requester at a time. It routes the granted transaction only to the other controllers and builds the share and fill inputs from their answers, so every cycle it produces stays within those assumptions. Processor requests are issued one at a time across the caches, which keeps local hits from ever meeting a snoop in the same cycle.

// File: rtl/wupd_pkg.sv
package wupd_pkg;
    typedef enum logic [1:0] {
        ST_EXC = 2'd0,
        ST_SHC = 2'd1,
        ST_SHM = 2'd2,
        ST_MOD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_UPD  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE, F_WB, F_RD, F_UPD, F_DONE
    } fsm_e;

    typedef enum logic [2:0] {
        A_RDHIT, A_WRLOC, A_WRUPD, A_MISS, A_MISS_WB
    } act_e;
endpackage

// File: rtl/wupd_snoop.sv
module wupd_snoop
    import wupd_pkg::*;
(
    input  logic     hit,
    input  bus_cmd_e cmd,
    input  line_st_e cur,
    output logic     shared,
    output logic     flush,
    output logic     wr_word,
    output line_st_e nxt
);
    always_comb begin
        shared  = 1'b0;
        flush   = 1'b0;
        wr_word = 1'b0;
        nxt     = cur;
        if (hit) begin
            shared = (cmd == BC_RD) || (cmd == BC_UPD);
            case (cmd)
                BC_RD: begin
                    case (cur)
                        ST_MOD:  begin flush = 1'b1; nxt = ST_SHM; end
                        ST_SHM:  flush = 1'b1;
                        ST_EXC:  nxt = ST_SHC;
                        default: nxt = cur;
                    endcase
                end
                BC_UPD: begin
                    if (cur == ST_SHC || cur == ST_SHM) begin
                        wr_word = 1'b1;
                        nxt     = ST_SHC;
                    end
                end
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/wupd_decide.sv
module wupd_decide
    import wupd_pkg::*;
(
    input  logic     valid,
    input  logic     tag_eq,
    input  logic     we,
    input  line_st_e cur,
    output act_e     act
);
    always_comb begin
        if (valid && tag_eq) begin
            if (!we)                               act = A_RDHIT;
            else if (cur == ST_EXC || cur == ST_MOD) act = A_WRLOC;
            else                                   act = A_WRUPD;
        end else if (valid && (cur == ST_SHM || cur == ST_MOD)) begin
            act = A_MISS_WB;
        end else begin
            act = A_MISS;
        end
    end
endmodule

// File: rtl/wupd_cache_ctrl.sv
module wupd_cache_ctrl
    import wupd_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int WORDS = 4,
    parameter int NSETS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [AW-1:0]       cpu_addr,
    input  logic [DW-1:0]       cpu_wdata,
    output logic                cpu_ready,
    output logic [DW-1:0]       cpu_rdata,
    output logic                bus_req_o,
    input  logic                bus_gnt_i,
    output logic [1:0]          bus_cmd_o,
    output logic [AW-1:0]       bus_addr_o,
    output logic [DW-1:0]       bus_word_o,
    output logic [WORDS*DW-1:0] bus_blk_o,
    input  logic [WORDS*DW-1:0] bus_blk_i,
    input  logic                bus_shared_i,
    input  logic                snp_valid_i,
    input  logic [1:0]          snp_cmd_i,
    input  logic [AW-1:0]       snp_addr_i,
    input  logic [DW-1:0]       snp_word_i,
    output logic                snp_shared_o,
    output logic                snp_flush_o,
    output logic [WORDS*DW-1:0] snp_blk_o
);
    localparam int WB = $clog2(WORDS);
    localparam int IB = $clog2(NSETS);
    localparam int TW = AW - IB - WB;

    typedef struct packed {
        fsm_e                                fsm;
        logic     [NSETS-1:0]                vld;
        line_st_e [NSETS-1:0]                st;
        logic     [NSETS-1:0][TW-1:0]        tag;
        logic     [NSETS-1:0][WORDS-1:0][DW-1:0] dat;
        logic                                we;
        logic     [AW-1:0]                   addr;
        logic     [DW-1:0]                   wdata;
        logic     [DW-1:0]                   rdata;
    } regs_t;

    regs_t r_q, r_d;

    // snoop side
    logic [IB-1:0] s_idx;
    logic [TW-1:0] s_tag;
    logic [WB-1:0] s_w;
    logic          s_hit, s_wr;
    line_st_e      s_nxt;
    bus_cmd_e      s_cmd;

    assign s_w   = snp_addr_i[WB-1:0];
    assign s_idx = snp_addr_i[WB +: IB];
    assign s_tag = snp_addr_i[AW-1 -: TW];
    assign s_cmd = bus_cmd_e'(snp_cmd_i);
    assign s_hit = snp_valid_i && r_q.vld[s_idx] && (r_q.tag[s_idx] == s_tag);

    wupd_snoop u_snoop (
        .hit(s_hit), .cmd(s_cmd), .cur(r_q.st[s_idx]),
        .shared(snp_shared_o), .flush(snp_flush_o), .wr_word(s_wr), .nxt(s_nxt)
    );
    assign snp_blk_o = r_q.dat[s_idx];

    // processor side
    logic [AW-1:0] op_addr;
    logic [IB-1:0] op_idx;
    logic [TW-1:0] op_tag;
    logic [WB-1:0] op_w;
    logic          op_we;
    logic          op_tag_eq;
    act_e          act;

    assign op_addr   = (r_q.fsm == F_IDLE) ? cpu_addr : r_q.addr;
    assign op_we     = (r_q.fsm == F_IDLE) ? cpu_we : r_q.we;
    assign op_w      = op_addr[WB-1:0];
    assign op_idx    = op_addr[WB +: IB];
    assign op_tag    = op_addr[AW-1 -: TW];
    assign op_tag_eq = (r_q.tag[op_idx] == op_tag);

    wupd_decide u_decide (
        .valid(r_q.vld[op_idx]), .tag_eq(op_tag_eq), .we(op_we),
        .cur(r_q.st[op_idx]), .act(act)
    );

    always_comb begin
        r_d        = r_q;
        bus_req_o  = 1'b0;
        bus_cmd_o  = BC_NONE;
        bus_addr_o = '0;
        bus_word_o = '0;
        bus_blk_o  = '0;

        if (s_hit) begin
            r_d.st[s_idx] = s_nxt;
            if (s_wr) r_d.dat[s_idx][s_w] = snp_word_i;
        end

        case (r_q.fsm)
            F_IDLE: begin
                if (cpu_req && !snp_valid_i) begin
                    r_d.we    = cpu_we;
                    r_d.addr  = cpu_addr;
                    r_d.wdata = cpu_wdata;
                    case (act)
                        A_RDHIT: begin
                            r_d.rdata = r_q.dat[op_idx][op_w];
                            r_d.fsm   = F_DONE;
                        end
                        A_WRLOC: begin
                            r_d.dat[op_idx][op_w] = cpu_wdata;
                            r_d.st[op_idx]        = ST_MOD;
                            r_d.fsm               = F_DONE;
                        end
                        A_WRUPD:   r_d.fsm = F_UPD;
                        A_MISS_WB: r_d.fsm = F_WB;
                        default:   r_d.fsm = F_RD;
                    endcase
                end
            end
            F_WB: begin
                bus_req_o  = 1'b1;
                bus_cmd_o  = BC_WB;
                bus_addr_o = {r_q.tag[op_idx], op_idx, {WB{1'b0}}};
                bus_blk_o  = r_q.dat[op_idx];
                if (bus_gnt_i) begin
                    r_d.vld[op_idx] = 1'b0;
                    r_d.fsm         = F_RD;
                end
            end
            F_RD: begin
                bus_req_o  = 1'b1;
                bus_cmd_o  = BC_RD;
                bus_addr_o = {op_tag, op_idx, {WB{1'b0}}};
                if (bus_gnt_i) begin
                    r_d.vld[op_idx] = 1'b1;
                    r_d.tag[op_idx] = op_tag;
                    r_d.dat[op_idx] = bus_blk_i;
                    if (!r_q.we) begin
                        r_d.st[op_idx] = bus_shared_i ? ST_SHC : ST_EXC;
                        r_d.rdata      = bus_blk_i[op_w*DW +: DW];
                        r_d.fsm        = F_DONE;
                    end else if (bus_shared_i) begin
                        r_d.st[op_idx] = ST_SHC;
                        r_d.fsm        = F_UPD;
                    end else begin
                        r_d.dat[op_idx][op_w] = r_q.wdata;
                        r_d.st[op_idx]        = ST_MOD;
                        r_d.fsm               = F_DONE;
                    end
                end
            end
            F_UPD: begin
                bus_req_o  = 1'b1;
                bus_cmd_o  = BC_UPD;
                bus_addr_o = r_q.addr;
                bus_word_o = r_q.wdata;
                if (bus_gnt_i) begin
                    r_d.dat[op_idx][op_w] = r_q.wdata;
                    r_d.st[op_idx]        = bus_shared_i ? ST_SHM : ST_MOD;
                    r_d.fsm               = F_DONE;
                end
            end
            default: r_d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.fsm <= F_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_ready = (r_q.fsm == F_DONE);
    assign cpu_rdata = r_q.rdata;

    // ---------------- assertions ----------------
    p_rd_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == F_RD && bus_gnt_i && !r_q.we) |=>
        (r_q.st[$past(op_idx)] == ($past(bus_shared_i) ? ST_SHC : ST_EXC)));

    p_wmiss_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == F_RD && bus_gnt_i && r_q.we && !bus_shared_i) |=>
        (r_q.fsm == F_DONE && r_q.st[$past(op_idx)] == ST_MOD));

    p_wmiss_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == F_RD && bus_gnt_i && r_q.we && bus_shared_i) |=> (r_q.fsm == F_UPD));

    p_excl_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == F_IDLE && cpu_req && cpu_we && !snp_valid_i && r_q.vld[op_idx]
         && op_tag_eq && r_q.st[op_idx] == ST_EXC) |=>
        (r_q.fsm == F_DONE && r_q.st[$past(op_idx)] == ST_MOD));

    p_upd_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == F_UPD && bus_gnt_i) |=>
        (r_q.st[$past(op_idx)] == ($past(bus_shared_i) ? ST_SHM : ST_MOD)));

    p_snoop_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_hit && s_cmd == BC_UPD) |=>
        (r_q.st[$past(s_idx)] == ST_SHC && r_q.dat[$past(s_idx)][$past(s_w)] == $past(snp_word_i)));

    p_flush_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush_o |=> (r_q.st[$past(s_idx)] == ST_SHM));

    p_wb_then_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == F_WB && bus_gnt_i) |=> (r_q.fsm == F_RD && !r_q.vld[$past(op_idx)]));

    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
endmodule

// File: tb/tb_wupd_cache_ctrl.sv
`timescale 1ns/1ps
module tb_wupd_cache_ctrl;
    localparam int NC = 3, AW = 8, DW = 16, WORDS = 4, NSETS = 4;
    localparam int BLK = WORDS * DW;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic           cpu_req [NC], cpu_we [NC], cpu_ready [NC];
    logic [AW-1:0]  cpu_addr [NC];
    logic [DW-1:0]  cpu_wdata [NC], cpu_rdata [NC];
    logic           bus_req [NC], gnt [NC], snp_valid [NC];
    logic [1:0]     cmd_o [NC];
    logic [AW-1:0]  addr_o [NC];
    logic [DW-1:0]  word_o [NC];
    logic [BLK-1:0] blk_o [NC], fblk [NC];
    logic           shared_o [NC], flush_o [NC];
    logic           bus_shr;
    logic [BLK-1:0] fill;
    logic [1:0]     m_cmd;
    logic [AW-1:0]  m_addr;
    logic [DW-1:0]  m_word;
    logic [BLK-1:0] m_blk;
    int             gidx;
    logic [DW-1:0]  mem [256];
    logic [DW-1:0]  gold [256];

    int n_chk = 0, n_fail = 0;
    int n_rd [NC], n_upd [NC], n_wb [NC], n_fl [NC];

    for (genvar g = 0; g < NC; g++) begin : g_c
        wupd_cache_ctrl #(.AW(AW), .DW(DW), .WORDS(WORDS), .NSETS(NSETS)) dut (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(cpu_req[g]), .cpu_we(cpu_we[g]), .cpu_addr(cpu_addr[g]),
            .cpu_wdata(cpu_wdata[g]), .cpu_ready(cpu_ready[g]), .cpu_rdata(cpu_rdata[g]),
            .bus_req_o(bus_req[g]), .bus_gnt_i(gnt[g]), .bus_cmd_o(cmd_o[g]),
            .bus_addr_o(addr_o[g]), .bus_word_o(word_o[g]), .bus_blk_o(blk_o[g]),
            .bus_blk_i(fill), .bus_shared_i(bus_shr),
            .snp_valid_i(snp_valid[g]), .snp_cmd_i(m_cmd), .snp_addr_i(m_addr),
            .snp_word_i(m_word), .snp_shared_o(shared_o[g]), .snp_flush_o(flush_o[g]),
            .snp_blk_o(fblk[g])
        );
    end

    // behavioural bus: lowest index wins, one transaction per cycle
    always_comb begin
        gidx = -1;
        for (int i = NC - 1; i >= 0; i--) if (bus_req[i]) gidx = i;
        m_cmd = 2'd0; m_addr = '0; m_word = '0; m_blk = '0;
        if (gidx >= 0) begin
            m_cmd = cmd_o[gidx]; m_addr = addr_o[gidx];
            m_word = word_o[gidx]; m_blk = blk_o[gidx];
        end
        for (int k = 0; k < WORDS; k++) fill[k*DW +: DW] = mem[{m_addr[AW-1:2], 2'(k)}];
        bus_shr = 1'b0;
        for (int i = 0; i < NC; i++) begin
            gnt[i] = (gidx == i);
            snp_valid[i] = (gidx >= 0) && (gidx != i) && (m_cmd == 2'd1 || m_cmd == 2'd2);
        end
        for (int i = 0; i < NC; i++) if (snp_valid[i] && shared_o[i]) bus_shr = 1'b1;
        for (int i = NC - 1; i >= 0; i--) if (flush_o[i]) fill = fblk[i];
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && gidx >= 0) begin
            int nf;
            nf = 0;
            case (m_cmd)
                2'd1: n_rd[gidx]++;
                2'd2: n_upd[gidx]++;
                2'd3: begin
                    n_wb[gidx]++;
                    for (int k = 0; k < WORDS; k++) mem[{m_addr[AW-1:2], 2'(k)}] = m_blk[k*DW +: DW];
                end
                default: ;
            endcase
            for (int i = 0; i < NC; i++) if (flush_o[i]) begin n_fl[i]++; nf++; end
            if (m_cmd == 2'd1) chk("R9 suppliers per fetch", (nf > 1) ? nf : 0, 0);
        end
    end

    task automatic clr();
        for (int i = 0; i < NC; i++) begin n_rd[i] = 0; n_upd[i] = 0; n_wb[i] = 0; n_fl[i] = 0; end
    endtask

    function automatic int total();
        int t = 0;
        for (int i = 0; i < NC; i++) t += n_rd[i] + n_upd[i] + n_wb[i];
        return t;
    endfunction

    task automatic op(input int c, input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, output logic [DW-1:0] rd);
        int t;
        clr();
        @(negedge clk);
        cpu_req[c] = 1'b1; cpu_we[c] = we; cpu_addr[c] = a; cpu_wdata[c] = d;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!cpu_ready[c] && t < 100);
        if (!cpu_ready[c]) chk("R10 request completes", 0, 1);
        rd = cpu_rdata[c];
        cpu_req[c] = 1'b0;
        if (we) gold[a] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [15:0] lf;
        for (int a = 0; a < 256; a++) begin mem[a] = DW'(a * 7 + 3); gold[a] = DW'(a * 7 + 3); end
        for (int i = 0; i < NC; i++) begin
            cpu_req[i] = 0; cpu_we[i] = 0; cpu_addr[i] = '0; cpu_wdata[i] = '0;
        end
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        for (int i = 0; i < NC; i++) begin
            chk("R11 no request after reset", int'(bus_req[i]), 0);
            chk("R11 ready low after reset", int'(cpu_ready[i]), 0);
        end
        // R1 read miss alone -> exclusive
        op(0, 0, 8'h10, 0, rd);
        chk("R1 read miss data", rd, gold[8'h10]);
        chk("R1 fetch count", n_rd[0], 1);
        chk("R1 no supplier", n_fl[0] + n_fl[1] + n_fl[2], 0);
        // R3 exclusive write silent
        op(0, 1, 8'h11, 16'hA1A1, rd);
        chk("R3 bus transactions", total(), 0);
        // R6 dirty line supplies
        op(1, 0, 8'h11, 0, rd);
        chk("R6 supplied word", rd, 16'hA1A1);
        chk("R6 dirty supplier", n_fl[0], 1);
        chk("R1 shared fetch count", n_rd[1], 1);
        // R4 / R7 shared-owned write broadcasts one word
        op(0, 1, 8'h12, 16'hB2B2, rd);
        chk("R4 update count", n_upd[0], 1);
        chk("R7 no block fetch for update", n_rd[0] + n_wb[0], 0);
        // R5 / R10 update visible in place, read hit silent
        op(1, 0, 8'h12, 0, rd);
        chk("R5 updated copy", rd, 16'hB2B2);
        chk("R10 read hit silent", total(), 0);
        // R4 from shared-clean
        op(1, 1, 8'h13, 16'hC3C3, rd);
        chk("R4 shared-clean write update", n_upd[1], 1);
        // R9 / R6 only the new owner supplies
        op(2, 0, 8'h10, 0, rd);
        chk("R6 owner supplies and stays", n_fl[1], 1);
        chk("R9 demoted copy silent", n_fl[0], 0);
        chk("R1 data from owner", rd, gold[8'h10]);
        // R2 write miss alone, R8 clean victim dropped
        op(2, 1, 8'h20, 16'hD4D4, rd);
        chk("R8 clean victim no writeback", n_wb[2], 0);
        chk("R2 lone write-miss fetch", n_rd[2], 1);
        chk("R2 lone write-miss no update", n_upd[2], 0);
        // R2 write miss with sharer
        op(0, 1, 8'h21, 16'hE5E5, rd);
        chk("R2 shared write-miss fetch", n_rd[0], 1);
        chk("R2 shared write-miss update", n_upd[0], 1);
        chk("R6 dirty supplier on write miss", n_fl[2], 1);
        chk("R8 clean victim no writeback", n_wb[0], 0);
        op(2, 0, 8'h21, 0, rd);
        chk("R5 update reached sharer", rd, 16'hE5E5);
        chk("R10 read hit silent", total(), 0);
        // R8 owned victim written back
        op(1, 0, 8'h30, 0, rd);
        chk("R8 owned victim writeback", n_wb[1], 1);
        chk("R8 fetch after writeback", n_rd[1], 1);
        chk("R1 data after eviction", rd, gold[8'h30]);
        op(2, 0, 8'h13, 0, rd);
        chk("R8 memory holds written-back word", rd, 16'hC3C3);
        chk("R8 no supplier left", n_fl[0] + n_fl[1] + n_fl[2], 0);
        // sweep: mixed traffic over a small address pool
        lf = 16'hACE1;
        for (int i = 0; i < 800; i++) begin
            int c;
            logic [AW-1:0] a;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            c = int'(lf[9:8]) % NC;
            a = {2'b00, lf[4:3], 1'b0, lf[5], lf[1:0]};
            if (lf[7]) op(c, 1, a, DW'(i * 37 + 5), rd);
            else begin
                op(c, 0, a, 0, rd);
                chk("R5 sweep read value", rd, gold[a]);
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule